// File: doc/BRIEF.md
# Two-Level Lookahead Adder/Subtractor

This block is a purely combinational 16-bit adder/subtractor. It forms every carry from generate and propagate terms in closed form instead of passing a carry from bit to bit. The bits are split into four groups of four. Inside each group, the carries into the bits come from sum-of-product equations in the per-bit generate and propagate and the group's own carry-in. A second lookahead stage works on the group-level generate and propagate. It produces the carry into each group and the final carry-out.

One mode input picks the operation. When it is high, the second operand is inverted bit by bit and the carry-in of the lowest bit is forced to one, so the same datapath yields the two's complement difference. The outputs are the 16-bit result, the carry out of bit 15 and a signed overflow flag. The flag is high when the carry into bit 15 differs from the carry out of it.

The block has no clock and no state. Its outputs follow the inputs after the settling delay of the lookahead logic. Data is not exchanged as a stream, so there is no valid/ready handshake and no back-pressure: the operands and the mode are plain level inputs.

Top module: `addsub_cla16`

## Requirements
- R1: With `sub_en` = 0, `result` equals (`op_a` + `op_b`) mod 2^16.
- R2: With `sub_en` = 1, `result` equals (`op_a` − `op_b`) mod 2^16, formed as `op_a` + ~`op_b` + 1.
- R3: With `sub_en` = 0, `carry_out` is bit 16 of the 17-bit unsigned sum `op_a` + `op_b`.
- R4: With `sub_en` = 1, `carry_out` is bit 16 of `op_a` + ~`op_b` + 1, which is 1 exactly when `op_a` ≥ `op_b` as unsigned numbers.
- R5: `ovf` is 1 exactly when `op_a` and the effective second operand (`op_b`, or ~`op_b` when subtracting) have the same bit 15 and `result` bit 15 differs from it. This equals the carry into bit 15 XOR the carry out of bit 15.
- R6: Subtracting zero returns `op_a` unchanged, with `carry_out` = 1 and `ovf` = 0.
- R7: A carry that arises in the lowest group reaches every higher group correctly. For example, 0xFFFF + 0x0001 gives `result` 0x0000 with `carry_out` = 1. Each group's carry-in equals the carry out of all lower bits.
- R8: Subtracting 0x8000 sets `ovf` exactly when `op_a` bit 15 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand (subtrahend when subtracting) |
| sub_en | input | 1 | 0 = add, 1 = subtract |
| result | output | 16 | Sum or difference |
| carry_out | output | 1 | Carry out of bit 15 |
| ovf | output | 1 | Signed overflow |

## Verification
The bench targets several corner cases, each with a distinct failure signature:
- **Full-length propagate chains** (0xFFFF + 1, 0x0FFF + 1, 0x00FF + 0x0001). A wrong group-level propagate term or a lost group carry-in shows up as a result stuck at 0xF000-style patterns with no carry-out.
- **Subtraction edges** (a − 0, a − a, 0 − 1, a − 0x8000). A missing carry-in injection gives a result that is one too small and a carry-out of 0 where 1 is due. A non-inverted operand returns the sum instead of the difference.
- **Signed boundary pairs** (0x7FFF + 1, 0x8000 + 0xFFFF, 0x8000 − 1). These separate a correct overflow from one that looks at the wrong carry or at unsigned carry-out.

Random operands in both modes fill in the rest.

// File: rtl/cla_pkg.sv
package cla_pkg;
  parameter int unsigned DEF_WIDTH   = 16;
  parameter int unsigned DEF_GROUP_W = 4;
endpackage

// File: rtl/cla_gp_cell.sv
module cla_gp_cell #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gen[i]  = x[i] & y[i];
    assign prop[i] = x[i] ^ y[i];
  end
endmodule

// File: rtl/cla_lookahead.sv
// Closed-form lookahead over N generate/propagate pairs.
// carries[j] is the carry into position j; carries[N] is the carry out.
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         cin,
  output logic [N:0]   carries,
  output logic         blk_gen,
  output logic         blk_prop
);
  // Group terms depend on gen/prop only.
  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      term = gen[k];
      for (int m = k + 1; m < int'(N); m++) term = term & prop[m];
      acc = acc | term;
    end
    blk_gen  = acc;
    blk_prop = &prop;
  end

  // Every carry is a sum of products of gen, prop and cin: no chain.
  always_comb begin
    logic acc;
    logic term;
    logic pall;
    carries[0] = cin;
    for (int j = 1; j <= int'(N); j++) begin
      acc  = 1'b0;
      for (int k = 0; k < j; k++) begin
        term = gen[k];
        for (int m = k + 1; m < j; m++) term = term & prop[m];
        acc = acc | term;
      end
      pall = cin;
      for (int m = 0; m < j; m++) pall = pall & prop[m];
      carries[j] = acc | pall;
    end
  end
endmodule

// File: rtl/addsub_cla16.sv
module addsub_cla16
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH   = DEF_WIDTH,
  parameter int unsigned GROUP_W = DEF_GROUP_W
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_en,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             ovf
);
  localparam int unsigned NGRP = WIDTH / GROUP_W;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] bit_g, bit_p;
  logic [WIDTH-1:0] bit_c;
  logic [NGRP-1:0]  grp_g, grp_p, grp_cout;
  logic [NGRP:0]    grp_carry;
  logic             top_g, top_p;

  assign b_eff = op_b ^ {WIDTH{sub_en}};

  cla_gp_cell #(.WIDTH(WIDTH)) u_gp (
    .x(op_a), .y(b_eff), .gen(bit_g), .prop(bit_p)
  );

  for (genvar k = 0; k < int'(NGRP); k++) begin : g_grp
    logic [GROUP_W:0] c_loc;
    cla_lookahead #(.N(GROUP_W)) u_la (
      .gen     (bit_g[k*GROUP_W +: GROUP_W]),
      .prop    (bit_p[k*GROUP_W +: GROUP_W]),
      .cin     (grp_carry[k]),
      .carries (c_loc),
      .blk_gen (grp_g[k]),
      .blk_prop(grp_p[k])
    );
    assign bit_c[k*GROUP_W +: GROUP_W] = c_loc[GROUP_W-1:0];
    assign grp_cout[k] = c_loc[GROUP_W];
  end

  cla_lookahead #(.N(NGRP)) u_blk (
    .gen     (grp_g),
    .prop    (grp_p),
    .cin     (sub_en),
    .carries (grp_carry),
    .blk_gen (top_g),
    .blk_prop(top_p)
  );

  assign result    = bit_p ^ bit_c;
  assign carry_out = grp_carry[NGRP];
  assign ovf       = bit_c[WIDTH-1] ^ grp_carry[NGRP];
endmodule

// File: rtl/addsub_cla16_chk.sv
module addsub_cla16_chk #(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned GROUP_W = 4,
  localparam int unsigned NGRP   = WIDTH / GROUP_W
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             sub_en,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             ovf,
  input logic [NGRP:0]    grp_carry,
  input logic [NGRP-1:0]  grp_cout,
  input logic             top_g,
  input logic             top_p
);
  logic [WIDTH-1:0] be;
  logic [WIDTH:0]   ref_sum;
  assign be      = sub_en ? ~op_b : op_b;
  assign ref_sum = {1'b0, op_a} + {1'b0, be} + {{WIDTH{1'b0}}, sub_en};

  always_comb begin
    logic [WIDTH:0] lo;
    logic [WIDTH:0] mask;
    if (!$isunknown({op_a, op_b, sub_en})) begin
      AST_SUM_MATCH: assert (result == ref_sum[WIDTH-1:0]); // R1
      AST_CARRY_MATCH: assert (carry_out == ref_sum[WIDTH]); // R3
      AST_SIGN_OVF: assert (ovf == ((op_a[WIDTH-1] == be[WIDTH-1]) && (result[WIDTH-1] != op_a[WIDTH-1]))); // R5
      AST_TOP_GP: assert (carry_out == (top_g | (top_p & sub_en))); // R4
      AST_SUB_ZERO: assert (!(sub_en && op_b == '0) || (result == op_a && carry_out && !ovf)); // R6
      for (int k = 1; k <= int'(NGRP); k++) begin
        mask = ({{WIDTH{1'b0}}, 1'b1} << (k * GROUP_W)) - 1'b1;
        lo   = ({1'b0, op_a} & mask) + ({1'b0, be} & mask) + {{WIDTH{1'b0}}, sub_en};
        AST_GROUP_CIN: assert (grp_carry[k] == lo[k*GROUP_W]); // R7
        AST_GROUP_HANDOFF: assert (grp_cout[k-1] == grp_carry[k]); // R7
      end
    end
  end
endmodule

bind addsub_cla16 addsub_cla16_chk #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) u_chk (
  .op_a(op_a), .op_b(op_b), .sub_en(sub_en), .result(result),
  .carry_out(carry_out), .ovf(ovf), .grp_carry(grp_carry),
  .grp_cout(grp_cout), .top_g(top_g), .top_p(top_p)
);

// File: tb/addsub_cla16_test.sv
module addsub_cla16_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  W = 16;

  typedef struct {
    logic [W-1:0] a, b;
    logic         s;
    logic [W-1:0] er;
    logic         ec, ev;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         sub_en = 1'b0;
  logic [W-1:0] result;
  logic         carry_out, ovf;

  item_t q[$];
  int n_vec = 0, n_bad = 0;
  bit   done = 1'b0;

  addsub_cla16 uut (
    .op_a(op_a), .op_b(op_b), .sub_en(sub_en),
    .result(result), .carry_out(carry_out), .ovf(ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic s, input string tag);
    item_t it;
    logic [W:0]   ext;
    logic [W-1:0] be;
    @(posedge clk);
    op_a = a; op_b = b; sub_en = s;
    be  = s ? ~b : b;
    ext = {1'b0, a} + {1'b0, be} + {{W{1'b0}}, s};
    it.a = a; it.b = b; it.s = s; it.tag = tag;
    it.er = ext[W-1:0];
    it.ec = ext[W];
    it.ev = (a[W-1] == be[W-1]) && (ext[W-1] != a[W-1]);
    q.push_back(it);
  endtask

  // Monitor: compares one queued item per falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_vec++;
        if (result !== it.er) begin
          n_bad++;
          $display("FAIL %s/%s result a=%h b=%h sub=%0d: got %h exp %h",
                   it.s ? "R2" : "R1", it.tag, it.a, it.b, it.s, result, it.er);
        end
        if (carry_out !== it.ec) begin
          n_bad++;
          $display("FAIL %s/%s carry a=%h b=%h sub=%0d: got %0b exp %0b",
                   it.s ? "R4" : "R3", it.tag, it.a, it.b, it.s, carry_out, it.ec);
        end
        if (ovf !== it.ev) begin
          n_bad++;
          $display("FAIL R5/%s ovf a=%h b=%h sub=%0d: got %0b exp %0b",
                   it.tag, it.a, it.b, it.s, ovf, it.ev);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] corners [12];
    corners = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h5555,
                16'hAAAA, 16'h000F, 16'h00F0, 16'h0F00, 16'hF000, 16'h1234};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R7: propagate chains across group boundaries
    apply(16'hFFFF, 16'h0001, 1'b0, "R7");
    apply(16'h0FFF, 16'h0001, 1'b0, "R7");
    apply(16'h00FF, 16'h0001, 1'b0, "R7");
    apply(16'h000F, 16'h0001, 1'b0, "R7");
    // R6: subtract zero
    apply(16'h1234, 16'h0000, 1'b1, "R6");
    apply(16'h8000, 16'h0000, 1'b1, "R6");
    // R8: subtract most negative value
    apply(16'h0000, 16'h8000, 1'b1, "R8");
    apply(16'h7FFF, 16'h8000, 1'b1, "R8");
    apply(16'hFFFF, 16'h8000, 1'b1, "R8");
    // R5: signed boundaries
    apply(16'h7FFF, 16'h0001, 1'b0, "R5");
    apply(16'h8000, 16'hFFFF, 1'b0, "R5");
    apply(16'h8000, 16'h0001, 1'b1, "R5");
    // R2, R4: difference and borrow
    apply(16'h0000, 16'h0001, 1'b1, "R4");
    apply(16'h4321, 16'h4321, 1'b1, "R2");
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int s = 0; s < 2; s++)
          apply(corners[i], corners[j], s[0], "corner");
    for (int n = 0; n < 3000; n++)
      apply(W'($urandom), W'($urandom), 1'($urandom), "random");
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule